// File: doc/BRIEF.md
# Fourth-Order Decimate-by-32 CIC Filter

This block is the first decimation stage behind a multilevel sigma-delta ADC modulator. Each time the high-rate clock enable is asserted it takes one 17-level modulator code. It maps the code to a signed value and passes it through four cascaded integrators. On every 32nd enable it samples the last integrator. Four comb sections then produce one wide two's complement word at 1/32 of the input rate, which lowers the rate from 128x to 4x the audio rate.

The filter has a sinc-to-the-fourth response with no droop compensation. Later stages handle compensation and further decimation. The integrators are not guarded against overflow: they wrap modulo 2^25, and the combs cancel the wraparound exactly. While the filter's memory is still filling after reset, a flag marks each output word as not yet settled.

Top module: `cic4_decim32`

## Requirements
- R1: The input code is a 5-bit unsigned level 0..16. It maps to the signed value code-8, giving -8..+8. Any code above 16 is treated as 16.
- R2: `out_valid` is a single-cycle pulse. It is raised in the clock cycle right after each enable whose count since reset is a multiple of 32, and at no other time.
- R3: Each output word equals the sum of the mapped inputs convolved with the 125-tap kernel whose coefficients are those of (1+z^-1+...+z^-31)^4. The newest tap is the enable that completes the group of 32, and inputs before reset count as zero.
- R4: The DC gain is 2^20. After settling, a constant mapped input v gives an output of v*1048576.
- R5: The integrators wrap modulo 2^25 with no saturation. Output words stay exact on long full-scale runs, during which the integrators overflow many times.
- R6: A cycle with `in_valid` low has no effect on the filter state or on the output timing.
- R7: `out_settled` is 0 on the first four output words after reset and 1 on every later word. It never falls except through reset.
- R8: Reset is synchronous and active low. It clears `out_valid`, `out_data` and `out_settled`, all filter memory and the decimation phase.
- R9: `out_data` holds its value in every cycle without an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High-rate sample enable |
| in_code | input | 5 | Modulator level code, 0..16 |
| out_valid | output | 1 | One-cycle strobe for a new output word |
| out_data | output | 25 | Decimated two's complement output word |
| out_settled | output | 1 | High once the filter memory has filled |

## Verification
An output word is due exactly one clock after the rising edge that samples the 32nd enable of its group. The chained integrator update and the comb differences are combinational, and only the output register lies in between.

On that same edge the driver computes the expected word from its own 125-tap convolution and queues it. The monitor samples on the falling edge. It pops one entry for each `out_valid` pulse, treats a pulse with an empty queue as an error, and checks that `out_data` holds between pulses. Gapped enables, clamped codes, long full-scale runs and a reset in the middle of a group are checked against the same model.

// File: rtl/cic_pkg.sv
package cic_pkg;
    // Modulator code width and number of distinct levels
    localparam int CIC_CODE_W = 5;
    localparam int CIC_LEVELS = 17;
    // Rate change and filter order
    localparam int CIC_RATE   = 32;
    localparam int CIC_ORDER  = 4;
    // Number of leading output words flagged as transient
    localparam int CIC_SETTLE = 4;
endpackage

// File: rtl/cic_phase_ctr.sv
module cic_phase_ctr #(
    parameter int RATE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic dec_tick
);
    localparam int PH_W = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(RATE - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ctr_t;

    ctr_t st_q, st_d;
    logic tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = 1'b0;
        if (in_valid) begin
            if (st_q.phase == LAST) begin
                st_d.phase = '0;
                tick_d     = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_tick = tick_d;

    generate
        if (RATE > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dec_tick |=> !dec_tick);
        end
    endgenerate
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
    parameter int IN_W  = 5,
    parameter int ACC_W = 25,
    parameter int ORDER = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  sample,
    output logic [ACC_W-1:0]        acc_next
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t st_q, st_d;
    logic [ACC_W-1:0] feed;

    always_comb begin
        st_d = st_q;
        feed = {{(ACC_W-IN_W){sample[IN_W-1]}}, sample};
        for (int k = 0; k < ORDER; k++) begin
            if (in_valid) begin
                // Modulo 2^ACC_W addition; wraparound is intended
                st_d.acc[k] = st_q.acc[k] + feed;
            end
            feed = st_d.acc[k];
        end
        acc_next = st_d.acc[ORDER-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
    parameter int ACC_W  = 25,
    parameter int ORDER  = 4,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ACC_W-1:0] sample,
    output logic [ACC_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_settled
);
    localparam int CNT_W = $clog2(SETTLE + 1) > 0 ? $clog2(SETTLE + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]            data;
        logic                        valid;
        logic                        settled;
        logic [CNT_W-1:0]            cnt;
    } comb_t;

    comb_t st_q, st_d;
    logic [ACC_W-1:0] stage;
    logic [ACC_W-1:0] diff;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        stage      = sample;
        diff       = '0;
        if (tick) begin
            for (int k = 0; k < ORDER; k++) begin
                diff        = stage - st_q.dly[k];
                st_d.dly[k] = stage;
                stage       = diff;
            end
            st_d.data    = stage;
            st_d.valid   = 1'b1;
            st_d.settled = (st_q.cnt == CNT_MAX);
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data    = st_q.data;
    assign out_valid   = st_q.valid;
    assign out_settled = st_q.settled;

    // R7
    settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_settled |=> out_settled);
    // R7
    settled_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_settled) |-> out_valid);
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

// File: rtl/cic4_decim32.sv
module cic4_decim32
    import cic_pkg::*;
#(
    parameter int CODE_W = CIC_CODE_W,
    parameter int LEVELS = CIC_LEVELS,
    parameter int RATE   = CIC_RATE,
    parameter int ORDER  = CIC_ORDER,
    parameter int SETTLE = CIC_SETTLE,
    parameter int OUT_W  = CODE_W + ORDER * $clog2(RATE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_settled
);
    localparam int GROWTH = ORDER * $clog2(RATE);
    localparam int ACC_W  = CODE_W + GROWTH;
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(LEVELS - 1);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'((LEVELS - 1) / 2);

    logic [CODE_W-1:0]        code_lim;
    logic signed [CODE_W-1:0] mapped;
    logic                     dec_tick;
    logic [ACC_W-1:0]         integ_out;
    logic [ACC_W-1:0]         comb_out;

    always_comb begin
        code_lim = (in_code > TOP_CODE) ? TOP_CODE : in_code;
        mapped   = signed'(code_lim - MID_CODE);
    end

    cic_phase_ctr #(.RATE(RATE)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dec_tick (dec_tick)
    );

    cic_integ #(.IN_W(CODE_W), .ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .sample   (mapped),
        .acc_next (integ_out)
    );

    cic_comb #(.ACC_W(ACC_W), .ORDER(ORDER), .SETTLE(SETTLE)) u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (dec_tick),
        .sample      (integ_out),
        .out_data    (comb_out),
        .out_valid   (out_valid),
        .out_settled (out_settled)
    );

    assign out_data = OUT_W'(comb_out);

    // R2
    strobe_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/cic4_decim32_test.sv
`timescale 1ns/1ps
module cic4_decim32_test;
    localparam int NTAP = 125;
    localparam int FULL = 8388608;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_code = '0;
    logic        out_valid;
    logic [24:0] out_data;
    logic        out_settled;

    always #10 clk = ~clk;

    cic4_decim32 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .out_valid(out_valid), .out_data(out_data), .out_settled(out_settled)
    );

    typedef struct {
        int    val;
        bit    settled;
        string req;
    } exp_t;

    exp_t  q[$];
    int    h[NTAP];
    int    xh[NTAP];
    int    en_cnt;
    int    out_idx;
    int    checks;
    int    fails;
    int    last_data;
    string cur_req = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int map_code(input int code);
        int c;
        c = (code > 16) ? 16 : code;
        return c - 8;
    endfunction

    task automatic clear_model();
        for (int k = 0; k < NTAP; k++) xh[k] = 0;
        en_cnt    = 0;
        out_idx   = 0;
        last_data = 0;
        q.delete();
    endtask

    task automatic drive(input int code, input bit en);
        exp_t e;
        int   s;
        @(negedge clk);
        in_valid = en;
        in_code  = code[4:0];
        @(posedge clk);
        if (en) begin
            for (int k = NTAP - 1; k > 0; k--) xh[k] = xh[k-1];
            xh[0] = map_code(code);
            en_cnt++;
            if (en_cnt % 32 == 0) begin
                s = 0;
                for (int k = 0; k < NTAP; k++) s += h[k] * xh[k];
                e.val     = s;
                e.settled = (out_idx >= 4);
                e.req     = cur_req;
                q.push_back(e);
                out_idx++;
            end
        end
    endtask

    task automatic run_const(input int code, input int n);
        for (int i = 0; i < n; i++) drive(code, 1'b1);
    endtask

    task automatic flush_and_check_empty(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(q.size() == 0, req, "pending outputs", q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_model();
        // R8: state while held in reset
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        check(out_data == '0, "R8", "out_data in reset", out_data, 0);
        check(out_settled == 1'b0, "R8", "out_settled in reset", out_settled, 0);
        rst_n = 1'b1;
    endtask

    // Scoreboard monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check($signed(out_data) == e.val, e.req, "out_data",
                          $signed(out_data), e.val);
                    check(out_settled == e.settled, "R7", "out_settled",
                          out_settled, e.settled);
                end
                last_data = $signed(out_data);
            end else if ($signed(out_data) != last_data) begin
                check(1'b0, "R9", "out_data changed without strobe",
                      $signed(out_data), last_data);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int tmp[NTAP];
        int len;
        for (int k = 0; k < NTAP; k++) h[k] = 0;
        h[0] = 1;
        len  = 1;
        for (int st = 0; st < 4; st++) begin
            for (int k = 0; k < NTAP; k++) tmp[k] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < 32; j++) tmp[i+j] += h[i];
            h = tmp;
            len += 31;
        end

        do_reset();

        // R4 and R5: long full-scale run, integrators wrap repeatedly
        cur_req = "R5";
        run_const(16, 32 * 40);
        flush_and_check_empty("R2");
        check(last_data == FULL, "R4", "DC gain +8", last_data, FULL);

        // R1: lowest code maps to -8
        cur_req = "R1";
        run_const(0, 32 * 6);
        flush_and_check_empty("R2");
        check(last_data == -FULL, "R1", "code 0 steady", last_data, -FULL);

        // R1: midscale code maps to zero
        run_const(8, 32 * 6);
        flush_and_check_empty("R2");
        check(last_data == 0, "R1", "code 8 steady", last_data, 0);

        // R1: codes above 16 clamp to +8
        run_const(31, 32 * 6);
        flush_and_check_empty("R2");
        check(last_data == FULL, "R1", "code 31 clamped", last_data, FULL);

        // R3 and R6: varied codes with idle gaps between enables
        cur_req = "R6";
        for (int i = 0; i < 32 * 8; i++) begin
            drive((i * 7) % 19, 1'b1);
            if (i % 3 == 0) drive(i % 17, 1'b0);
            if (i % 5 == 0) drive(2, 1'b0);
        end
        flush_and_check_empty("R2");

        // R3: alternating extremes
        cur_req = "R3";
        for (int i = 0; i < 32 * 6; i++) drive((i % 2) ? 16 : 0, 1'b1);
        flush_and_check_empty("R2");

        // R8: reset in the middle of a group restarts phase and settle count
        run_const(12, 45);
        do_reset();
        cur_req = "R8";
        run_const(4, 32 * 7);
        flush_and_check_empty("R2");
        check(last_data == -4 * 1048576, "R4", "DC after mid reset",
              last_data, -4 * 1048576);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule